// File: doc/BRIEF.md
# Differential Clock Output Gate Controller

This block decides, for each of several differential clock outputs, whether the output toggles, is parked at a fixed driven level, or is released to high impedance. It takes an enable pin for the first output and one for the last, a stop pin, a power-down pin, and one pin that inverts the sense of those four pins. It also takes a set of control-register bits: one run-enable bit and one stop-mask bit per output, a high-impedance choice for power-down, a high-impedance choice for stop, and a rate select.

The block also produces the gated clock itself. In a small digital model, `clk` stands for the fast reference. The output clock runs at half the `clk` rate in normal mode and at a quarter of it in halved mode.

All pins pass through a two-flop synchroniser first. A change to an output's state is committed only at the moment its clock falls. A stop therefore never cuts a high or low phase short, and a restart always begins with a whole period.

Top module: `clkout_gate_ctrl`

## Requirements
- R1: With `inv_pin` at 0, the enable, stop and power-down pins keep their sense. With it at 1, all four are inverted before they are used.
- R2: After the polarity correction, `oe_a_pin` is an active-high enable for output 0 only, and `oe_b_pin` is an active-high enable for output N_OUT-1 only. The other outputs have no pin enable.
- R3: Power-down is active when the corrected `pwrdn_pin` is 0. While it is active, every output stops: high impedance if `cfg_pd_hiz` is 1, driven park otherwise.
- R4: Stop is active when the corrected `stop_pin` is 0. While it is active, only outputs whose `cfg_stop_mask` bit is 1 stop. They go to high impedance if `cfg_stop_hiz` is 1, and to driven park otherwise.
- R5: In driven park, `clk_p_o` is held at 1 and `clk_n_o` at 0, with `park_o` at 1. In high impedance, `hiz_o` is 1 and both clock outputs read 0.
- R6: An output runs only when its `cfg_out_en` bit is 1 and its pin enable (if it has one) is asserted. A disabled output goes to high impedance. Exactly one of `run_o`, `park_o` and `hiz_o` is 1 per output.
- R7: When `cfg_full_rate` is 1, a running output toggles on every `clk` edge. When it is 0, a running output toggles on every second edge.
- R8: An output's state changes only at a falling edge of the output clock. No high or low phase is shorter than one nominal half period.
- R9: Power-down takes priority over stop, and stop takes priority over the enables, in choosing the state.
- R10: While `rst` is high, every output is in high impedance with both clock lines at 0. A running output has `clk_n_o` equal to the inverse of `clk_p_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| inv_pin | input | 1 | Polarity flip for the four control pins |
| oe_a_pin | input | 1 | Pin enable for output 0 |
| oe_b_pin | input | 1 | Pin enable for output N_OUT-1 |
| stop_pin | input | 1 | Stop request, active low after correction |
| pwrdn_pin | input | 1 | Power-down request, active low after correction |
| cfg_full_rate | input | 1 | 1 selects normal rate, 0 selects halved rate |
| cfg_pd_hiz | input | 1 | Power-down parks in high impedance when 1 |
| cfg_stop_hiz | input | 1 | Stop parks in high impedance when 1 |
| cfg_out_en | input | N_OUT | Per-output run enable |
| cfg_stop_mask | input | N_OUT | Per-output stop participation |
| run_o | output | N_OUT | Output is toggling |
| park_o | output | N_OUT | Output is parked and driven |
| hiz_o | output | N_OUT | Output is released |
| clk_p_o | output | N_OUT | True clock line |
| clk_n_o | output | N_OUT | Complement clock line |

## Verification
Every combination of the five pins is applied under each pairing of the two park-mode bits and the rate select. This is repeated with three mixes of enable and mask bits that leave different outputs exposed to stop. Those patterns separate the inversion of each pin, the single-output reach of each pin enable, the priority of power-down over stop over enable, and toggle counts that tell normal rate from halved rate. A separate run of stop and restart requests at every phase offset in halved mode shows whether a phase shorter than two `clk` cycles ever appears.

// File: rtl/clkout_gate_pkg.sv
package clkout_gate_pkg;
  typedef enum logic [1:0] {
    OUT_HIZ  = 2'd0,
    OUT_PARK = 2'd1,
    OUT_RUN  = 2'd2
  } out_state_e;

  localparam int unsigned PIN_COUNT = 5;
  localparam int unsigned PIN_OE_A  = 0;
  localparam int unsigned PIN_OE_B  = 1;
  localparam int unsigned PIN_STOP  = 2;
  localparam int unsigned PIN_PD    = 3;
  localparam int unsigned PIN_INV   = 4;
endpackage

// File: rtl/clkout_pin_sync.sv
module clkout_pin_sync #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/clkout_phase_gen.sv
module clkout_phase_gen (
  input  logic clk,
  input  logic rst,
  input  logic full_rate_i,
  output logic ph_next_o,
  output logic fall_tick_o
);
  logic pre_q;
  logic ph_q;
  logic step;

  assign step        = full_rate_i | pre_q;
  assign ph_next_o   = ph_q ^ step;
  assign fall_tick_o = step & ph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= 1'b0;
      ph_q  <= 1'b0;
    end else begin
      pre_q <= ~pre_q;
      ph_q  <= ph_next_o;
    end
  end

  AST_HALF_RATE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!full_rate_i && !$past(full_rate_i) && (ph_q != $past(ph_q))) |=> $stable(ph_q)); // R7
endmodule

// File: rtl/clkout_lane.sv
module clkout_lane
  import clkout_gate_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fall_tick_i,
  input  logic ph_next_i,
  input  logic pd_act_i,
  input  logic stop_act_i,
  input  logic mask_i,
  input  logic en_i,
  input  logic pd_hiz_i,
  input  logic stop_hiz_i,
  output logic run_o,
  output logic park_o,
  output logic hiz_o,
  output logic p_o,
  output logic n_o
);
  out_state_e st_q, st_want, st_nxt;

  always_comb begin
    if (pd_act_i)                st_want = pd_hiz_i ? OUT_HIZ : OUT_PARK;
    else if (stop_act_i && mask_i) st_want = stop_hiz_i ? OUT_HIZ : OUT_PARK;
    else if (en_i)               st_want = OUT_RUN;
    else                         st_want = OUT_HIZ;
  end

  assign st_nxt = fall_tick_i ? st_want : st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= OUT_HIZ;
      p_o  <= 1'b0;
      n_o  <= 1'b0;
    end else begin
      st_q <= st_nxt;
      p_o  <= (st_nxt == OUT_RUN) ? ph_next_i  : (st_nxt == OUT_PARK);
      n_o  <= (st_nxt == OUT_RUN) ? ~ph_next_i : 1'b0;
    end
  end

  assign run_o  = (st_q == OUT_RUN);
  assign park_o = (st_q == OUT_PARK);
  assign hiz_o  = (st_q == OUT_HIZ);

  AST_STATE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (st_q != $past(st_q)) |-> $past(fall_tick_i)); // R8
  AST_PARK_LEVELS: assert property (@(posedge clk) disable iff (rst)
    park_o |-> (p_o && !n_o)); // R5
  AST_HIZ_QUIET: assert property (@(posedge clk) disable iff (rst)
    hiz_o |-> (!p_o && !n_o)); // R5
  AST_RUN_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    run_o |-> (n_o == !p_o)); // R10
  AST_ONE_STATE: assert property (@(posedge clk) disable iff (rst)
    $countones({run_o, park_o, hiz_o}) == 1); // R6
endmodule

// File: rtl/clkout_gate_ctrl.sv
module clkout_gate_ctrl
  import clkout_gate_pkg::*;
#(
  parameter int unsigned N_OUT       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inv_pin,
  input  logic             oe_a_pin,
  input  logic             oe_b_pin,
  input  logic             stop_pin,
  input  logic             pwrdn_pin,
  input  logic             cfg_full_rate,
  input  logic             cfg_pd_hiz,
  input  logic             cfg_stop_hiz,
  input  logic [N_OUT-1:0] cfg_out_en,
  input  logic [N_OUT-1:0] cfg_stop_mask,
  output logic [N_OUT-1:0] run_o,
  output logic [N_OUT-1:0] park_o,
  output logic [N_OUT-1:0] hiz_o,
  output logic [N_OUT-1:0] clk_p_o,
  output logic [N_OUT-1:0] clk_n_o
);
  localparam int unsigned LAST_IDX = N_OUT - 1;

  logic [PIN_COUNT-1:0] pins_raw, pins_s;
  logic inv_s, oe_a_c, oe_b_c, stop_act, pd_act;
  logic ph_next, fall_tick;
  logic [N_OUT-1:0] pin_en;

  assign pins_raw[PIN_OE_A] = oe_a_pin;
  assign pins_raw[PIN_OE_B] = oe_b_pin;
  assign pins_raw[PIN_STOP] = stop_pin;
  assign pins_raw[PIN_PD]   = pwrdn_pin;
  assign pins_raw[PIN_INV]  = inv_pin;

  clkout_pin_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (pins_raw),
    .q_o (pins_s)
  );

  assign inv_s    = pins_s[PIN_INV];
  assign oe_a_c   = pins_s[PIN_OE_A] ^ inv_s;
  assign oe_b_c   = pins_s[PIN_OE_B] ^ inv_s;
  assign stop_act = ~(pins_s[PIN_STOP] ^ inv_s);
  assign pd_act   = ~(pins_s[PIN_PD] ^ inv_s);

  clkout_phase_gen u_phase (
    .clk         (clk),
    .rst         (rst),
    .full_rate_i (cfg_full_rate),
    .ph_next_o   (ph_next),
    .fall_tick_o (fall_tick)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_lane
    if (i == 0) begin : g_pin_a
      assign pin_en[i] = oe_a_c;
    end else if (i == LAST_IDX) begin : g_pin_b
      assign pin_en[i] = oe_b_c;
    end else begin : g_no_pin
      assign pin_en[i] = 1'b1;
    end

    clkout_lane u_lane (
      .clk         (clk),
      .rst         (rst),
      .fall_tick_i (fall_tick),
      .ph_next_i   (ph_next),
      .pd_act_i    (pd_act),
      .stop_act_i  (stop_act),
      .mask_i      (cfg_stop_mask[i]),
      .en_i        (cfg_out_en[i] & pin_en[i]),
      .pd_hiz_i    (cfg_pd_hiz),
      .stop_hiz_i  (cfg_stop_hiz),
      .run_o       (run_o[i]),
      .park_o      (park_o[i]),
      .hiz_o       (hiz_o[i]),
      .p_o         (clk_p_o[i]),
      .n_o         (clk_n_o[i])
    );
  end

  AST_PD_STOPS_ALL: assert property (@(posedge clk) disable iff (rst)
    ($past(pd_act) && $past(fall_tick)) |-> (run_o == '0)); // R3
  AST_RESET_RELEASED: assert property (@(posedge clk)
    $past(rst) |-> (hiz_o == {N_OUT{1'b1}})); // R10
endmodule

// File: tb/clkout_gate_ctrl_tb_top.sv
module clkout_gate_ctrl_tb_top;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst;
  logic inv_pin, oe_a_pin, oe_b_pin, stop_pin, pwrdn_pin;
  logic cfg_full_rate, cfg_pd_hiz, cfg_stop_hiz;
  logic [N-1:0] cfg_out_en, cfg_stop_mask;
  logic [N-1:0] run_o, park_o, hiz_o, clk_p_o, clk_n_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  clkout_gate_ctrl #(.N_OUT(N), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .inv_pin(inv_pin), .oe_a_pin(oe_a_pin), .oe_b_pin(oe_b_pin),
    .stop_pin(stop_pin), .pwrdn_pin(pwrdn_pin), .cfg_full_rate(cfg_full_rate),
    .cfg_pd_hiz(cfg_pd_hiz), .cfg_stop_hiz(cfg_stop_hiz), .cfg_out_en(cfg_out_en),
    .cfg_stop_mask(cfg_stop_mask), .run_o(run_o), .park_o(park_o), .hiz_o(hiz_o),
    .clk_p_o(clk_p_o), .clk_n_o(clk_n_o)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected state: 0 hiz, 1 park, 2 run (R1 R2 R3 R4 R6 R9)
  function automatic int exp_state(input int i, input logic [4:0] pins, input logic pdh,
                                   input logic sth, input logic [N-1:0] en, input logic [N-1:0] msk);
    logic inv, oea, oeb, st_act, pd_act, pen;
    inv    = pins[4];
    oea    = pins[0] ^ inv;
    oeb    = pins[1] ^ inv;
    st_act = !(pins[2] ^ inv);
    pd_act = !(pins[3] ^ inv);
    pen    = (i == 0) ? oea : ((i == N-1) ? oeb : 1'b1);
    if (pd_act) return pdh ? 0 : 1;
    if (st_act && msk[i]) return sth ? 0 : 1;
    if (en[i] && pen) return 2;
    return 0;
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] samp_p [9];
    logic [N-1:0] samp_n [9];
    logic [N-1:0] en_tab [3];
    logic [N-1:0] msk_tab [3];
    en_tab[0] = 4'b1111; msk_tab[0] = 4'b1111;
    en_tab[1] = 4'b1010; msk_tab[1] = 4'b0101;
    en_tab[2] = 4'b0111; msk_tab[2] = 4'b1100;

    rst = 1'b1;
    {inv_pin, oe_a_pin, oe_b_pin, stop_pin, pwrdn_pin} = '0;
    cfg_full_rate = 1'b1; cfg_pd_hiz = 1'b0; cfg_stop_hiz = 1'b0;
    cfg_out_en = '1; cfg_stop_mask = '0;
    repeat (3) @(negedge clk);
    check(hiz_o == 4'hF && run_o == 0 && park_o == 0, "R10", "reset hiz", hiz_o, 15);
    check(clk_p_o == 0 && clk_n_o == 0, "R10", "reset lines", clk_p_o, 0);
    @(negedge clk);
    rst = 1'b0;

    // exhaustive pin sweep (R1 R2 R3 R4 R5 R6 R7 R9 R10)
    for (int c = 0; c < 8; c++) begin
      for (int t = 0; t < 3; t++) begin
        for (int pv = 0; pv < 32; pv++) begin
          logic [4:0] pins;
          pins = pv[4:0];
          @(negedge clk);
          cfg_full_rate = c[0]; cfg_pd_hiz = c[1]; cfg_stop_hiz = c[2];
          cfg_out_en = en_tab[t]; cfg_stop_mask = msk_tab[t];
          oe_a_pin = pins[0]; oe_b_pin = pins[1]; stop_pin = pins[2];
          pwrdn_pin = pins[3]; inv_pin = pins[4];
          repeat (12) @(negedge clk);
          for (int k = 0; k < 9; k++) begin
            samp_p[k] = clk_p_o;
            samp_n[k] = clk_n_o;
            if (k < 8) @(negedge clk);
          end
          for (int i = 0; i < N; i++) begin
            int es, tog;
            bit ok;
            es = exp_state(i, pins, c[1], c[2], en_tab[t], msk_tab[t]);
            tog = 0;
            ok = 1;
            for (int k = 1; k < 9; k++) if (samp_p[k][i] != samp_p[k-1][i]) tog++;
            if (es == 2) begin
              for (int k = 0; k < 9; k++) if (samp_n[k][i] != !samp_p[k][i]) ok = 0;
              check(run_o[i] && !park_o[i] && !hiz_o[i], "R6", "run flag", {run_o[i], park_o[i], hiz_o[i]}, 4);
              check(tog == (c[0] ? 8 : 4), "R7", "toggle count", tog, c[0] ? 8 : 4);
              check(ok, "R10", "complement", 0, 1);
            end else if (es == 1) begin
              for (int k = 0; k < 9; k++) if (!samp_p[k][i] || samp_n[k][i]) ok = 0;
              check(park_o[i] && !run_o[i] && !hiz_o[i], "R9", "park flag", {run_o[i], park_o[i], hiz_o[i]}, 2);
              check(ok, "R5", "park levels", samp_p[0][i], 1);
            end else begin
              for (int k = 0; k < 9; k++) if (samp_p[k][i] || samp_n[k][i]) ok = 0;
              check(hiz_o[i] && !run_o[i] && !park_o[i], "R3", "hiz flag", {run_o[i], park_o[i], hiz_o[i]}, 1);
              check(ok, "R4", "hiz lines", samp_p[0][i], 0);
            end
          end
        end
      end
    end

    // stop/restart at every phase offset in halved mode (R8)
    @(negedge clk);
    inv_pin = 0; oe_a_pin = 1; oe_b_pin = 1; pwrdn_pin = 1; stop_pin = 1;
    cfg_full_rate = 0; cfg_stop_hiz = 0; cfg_out_en = '1; cfg_stop_mask = 4'b0001;
    repeat (12) @(negedge clk);
    for (int off = 0; off < 4; off++) begin
      int seg;
      logic prev;
      bit ok;
      repeat (off) @(negedge clk);
      prev = clk_p_o[0];
      seg = -100;
      ok = 1;
      for (int k = 0; k < 60; k++) begin
        if (k == 5)  stop_pin = 0;
        if (k == 23 + off) stop_pin = 1;
        @(negedge clk);
        if (clk_p_o[0] != prev) begin
          if (seg >= 0 && seg < 2) ok = 0;
          seg = 1;
          prev = clk_p_o[0];
        end else seg++;
        if (clk_p_o[1] == 1 && clk_n_o[1] == 1) ok = 0;
      end
      check(ok, "R8", "no short phase", seg, 2);
      check(run_o[0], "R8", "restart runs", run_o[0], 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule